// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits behind a receiver that delivers nine-bit characters from a shared multidrop serial link. It decides which of those characters reach the local node. Bit 8 of each character is a mark. A marked character carries a station address. An unmarked character carries payload. The filter keeps one bit of state: the node is either waiting for its address (listening) or addressed (selected). Only while the node is selected do payload characters pass to the local side. Address characters are consumed by the filter and never appear as payload.

The node address is an input, so software or straps can set it. An optional broadcast address, all ones by default, selects every node when the parameter enables it. Clearing the enable input turns the filter into a plain pass-through: every received character is delivered and the selection is dropped.

All outputs are registered. A character that is presented in one cycle has its effect visible after the next rising clock edge.

Top module: `mdrop_addr_filter`

## Requirements
- R1: A character is taken only in a cycle where `rx_valid` is high. Bit 8 of `rx_char` is the mark (1 = address character, 0 = data character) and bits 7:0 are the payload. Every effect appears on the outputs one clock edge after the character is taken.
- R2: While the node is listening and the filter is enabled, data characters are discarded: `out_valid` stays low.
- R3: An address character whose payload equals `node_addr` moves the node to selected. `selected` goes high, and `addr_hit` is high for exactly the one cycle after that character.
- R4: While the node is selected and the filter is enabled, each data character is delivered one cycle later, with `out_valid` high for one cycle and `out_data` equal to its bits 7:0.
- R5: While the filter is enabled, an address character never raises `out_valid`, whether it matches or not.
- R6: An address character that matches neither the node address nor an enabled broadcast address leaves the node listening, or returns it to listening. Data characters that follow are dropped.
- R7: With broadcast enabled (the default), an address character with payload 0xFF selects the node and pulses `addr_hit`, whatever `node_addr` holds.
- R8: While `filt_en` is low, every valid character (address or data) is delivered on `out_data`/`out_valid` one cycle later, `selected` is low, and `addr_hit` stays low.
- R9: Reset (synchronous, active high `rst`) puts the node in the listening state with `out_valid` and `addr_hit` low. This applies even if the node was selected.
- R10: A cycle with `rx_valid` low changes nothing: `out_valid` and `addr_hit` stay low and `selected` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | 1 = address filtering, 0 = pass everything |
| node_addr | input | 8 | Address of this station |
| rx_valid | input | 1 | `rx_char` holds a new character |
| rx_char | input | 9 | Received character; bit 8 is the address mark |
| out_data | output | 8 | Delivered payload |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| selected | output | 1 | Node is currently addressed |
| addr_hit | output | 1 | One-cycle pulse after a matching address character |

## Verification
Two functions can fall in the same cycle: the filter being switched off, and an address character that matches this node. The bench provokes this by lowering `filt_en` in the very cycle that a matching marked character arrives. The correct result is judged on the next cycle: the character must come out as payload, `selected` must read low, and `addr_hit` must stay low. The bench also sends a mismatching address while the node is selected. It checks that the same edge both deselects the node and suppresses any output.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

   typedef enum logic {
      ST_LISTEN   = 1'b0,
      ST_SELECTED = 1'b1
   } mdf_state_e;

   typedef enum logic [1:0] {
      EV_NONE      = 2'd0,
      EV_DATA      = 2'd1,
      EV_ADDR_HIT  = 2'd2,
      EV_ADDR_MISS = 2'd3
   } mdf_event_e;

endpackage

// File: rtl/mdf_decode.sv
module mdf_decode
   import mdf_pkg::*;
#(
   parameter int              PAY_W      = 8,
   parameter bit              BCAST_EN   = 1'b1,
   parameter logic [PAY_W-1:0] BCAST_ADDR = '1,
   localparam int             CHAR_W     = PAY_W + 1,
   localparam int             MARK_BIT   = PAY_W
) (
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic [PAY_W-1:0]  node_addr,
   output mdf_event_e        ev,
   output logic [PAY_W-1:0]  payload
);

   logic is_mark;
   logic own_match;
   logic bc_match;

   assign payload   = rx_char[PAY_W-1:0];
   assign is_mark   = rx_char[MARK_BIT];
   assign own_match = (payload == node_addr);

   generate
      if (BCAST_EN) begin : g_bcast
         assign bc_match = (payload == BCAST_ADDR);
      end else begin : g_no_bcast
         assign bc_match = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!rx_valid) begin
         ev = EV_NONE;
      end else if (!is_mark) begin
         ev = EV_DATA;
      end else if (own_match || bc_match) begin
         ev = EV_ADDR_HIT;
      end else begin
         ev = EV_ADDR_MISS;
      end
   end

endmodule

// File: rtl/mdf_select_fsm.sv
module mdf_select_fsm
   import mdf_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       filt_en,
   input  mdf_event_e ev,
   output mdf_state_e state,
   output logic       hit_pulse
);

   mdf_state_e state_n;

   always_comb begin
      state_n = state;
      if (!filt_en) begin
         state_n = ST_LISTEN;
      end else begin
         case (ev)
            EV_ADDR_HIT:  state_n = ST_SELECTED;
            EV_ADDR_MISS: state_n = ST_LISTEN;
            default:      state_n = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_LISTEN;
         hit_pulse <= 1'b0;
      end else begin
         state     <= state_n;
         hit_pulse <= filt_en && (ev == EV_ADDR_HIT);
      end
   end

endmodule

// File: rtl/mdf_emit.sv
module mdf_emit
   import mdf_pkg::*;
#(
   parameter int PAY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             filt_en,
   input  mdf_event_e       ev,
   input  mdf_state_e       state,
   input  logic [PAY_W-1:0] payload,
   output logic [PAY_W-1:0] out_data,
   output logic             out_valid
);

   logic pass_raw;
   logic pass_sel;
   logic take;

   assign pass_raw = !filt_en && (ev != EV_NONE);
   assign pass_sel = filt_en && (ev == EV_DATA) && (state == ST_SELECTED);
   assign take     = pass_raw || pass_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_data <= payload;
         end
      end
   end

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
   import mdf_pkg::*;
#(
   parameter int               PAY_W      = 8,
   parameter bit               BCAST_EN   = 1'b1,
   parameter logic [PAY_W-1:0] BCAST_ADDR = '1,
   localparam int              CHAR_W     = PAY_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              filt_en,
   input  logic [PAY_W-1:0]  node_addr,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   output logic [PAY_W-1:0]  out_data,
   output logic              out_valid,
   output logic              selected,
   output logic              addr_hit
);

   generate
      if (PAY_W < 2 || PAY_W > 32) begin : g_bad_width
         $error("mdrop_addr_filter: PAY_W must lie in 2..32");
      end
   endgenerate

   mdf_event_e       ev;
   mdf_state_e       state;
   logic [PAY_W-1:0] payload;

   mdf_decode #(
      .PAY_W      (PAY_W),
      .BCAST_EN   (BCAST_EN),
      .BCAST_ADDR (BCAST_ADDR)
   ) u_decode (
      .rx_valid  (rx_valid),
      .rx_char   (rx_char),
      .node_addr (node_addr),
      .ev        (ev),
      .payload   (payload)
   );

   mdf_select_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .filt_en   (filt_en),
      .ev        (ev),
      .state     (state),
      .hit_pulse (addr_hit)
   );

   mdf_emit #(
      .PAY_W (PAY_W)
   ) u_emit (
      .clk       (clk),
      .rst       (rst),
      .filt_en   (filt_en),
      .ev        (ev),
      .state     (state),
      .payload   (payload),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   assign selected = (state == ST_SELECTED);

endmodule

// File: rtl/mdf_checker.sv
module mdf_checker #(
   parameter int PAY_W  = 8,
   localparam int CHAR_W = PAY_W + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              filt_en,
   input logic [PAY_W-1:0]  node_addr,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_char,
   input logic [PAY_W-1:0]  out_data,
   input logic              out_valid,
   input logic              selected,
   input logic              addr_hit
);

   // R5: a marked character never yields payload while filtering
   p_addr_not_out_r5: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && rx_char[PAY_W] && filt_en) |=> !out_valid);

   // R2: unmarked characters are dropped while listening
   p_listen_drop_r2: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !rx_char[PAY_W] && filt_en && !selected) |=> !out_valid);

   // R3: a hit pulse is always accompanied by selection
   p_hit_sel_r3: assert property (@(posedge clk) disable iff (rst)
      addr_hit |-> selected);

   // R4: a data character while selected is delivered unchanged
   p_deliver_r4: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !rx_char[PAY_W] && filt_en && selected)
      |=> (out_valid && out_data == $past(rx_char[PAY_W-1:0])));

   // R8: bypass delivers everything and clears selection
   p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !filt_en)
      |=> (out_valid && !selected && !addr_hit
           && out_data == $past(rx_char[PAY_W-1:0])));

   // R10: idle cycles while filtering keep the selection
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!rx_valid && filt_en) |=> ($stable(selected) && !out_valid && !addr_hit));

   // R9: leaving reset finds the node listening
   p_reset_listen_r9: assert property (@(posedge clk)
      $fell(rst) |-> (!selected && !out_valid && !addr_hit));

endmodule

bind mdrop_addr_filter mdf_checker #(.PAY_W(PAY_W)) u_mdf_checker (
   .clk       (clk),
   .rst       (rst),
   .filt_en   (filt_en),
   .node_addr (node_addr),
   .rx_valid  (rx_valid),
   .rx_char   (rx_char),
   .out_data  (out_data),
   .out_valid (out_valid),
   .selected  (selected),
   .addr_hit  (addr_hit)
);

// File: tb/mdrop_addr_filter_test.sv
module mdrop_addr_filter_test;

   localparam int NVEC = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       filt_en = 1'b1;
   logic [7:0] node_addr = 8'h3C;
   logic       rx_valid = 1'b0;
   logic [8:0] rx_char = '0;
   logic [7:0] out_data;
   logic       out_valid;
   logic       selected;
   logic       addr_hit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mdrop_addr_filter uut (
      .clk       (clk),
      .rst       (rst),
      .filt_en   (filt_en),
      .node_addr (node_addr),
      .rx_valid  (rx_valid),
      .rx_char   (rx_char),
      .out_data  (out_data),
      .out_valid (out_valid),
      .selected  (selected),
      .addr_hit  (addr_hit)
   );

   // [25:22] req, [21] en, [20] valid, [19:11] char,
   // [10] exp valid, [9:2] exp data, [1] exp selected, [0] exp hit
   localparam logic [25:0] VEC [0:NVEC-1] = '{
      {4'd2,  1'b1, 1'b1, 9'h012, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 data while listening
      {4'd6,  1'b1, 1'b1, 9'h155, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 foreign address
      {4'd3,  1'b1, 1'b1, 9'h13C, 1'b0, 8'h00, 1'b1, 1'b1}, // R3 own address
      {4'd4,  1'b1, 1'b1, 9'h0A5, 1'b1, 8'hA5, 1'b1, 1'b0}, // R4 deliver
      {4'd10, 1'b1, 1'b0, 9'h077, 1'b0, 8'h00, 1'b1, 1'b0}, // R10 no valid
      {4'd4,  1'b1, 1'b1, 9'h000, 1'b1, 8'h00, 1'b1, 1'b0}, // R4 zero
      {4'd5,  1'b1, 1'b1, 9'h13C, 1'b0, 8'h00, 1'b1, 1'b1}, // R5 repeat own address
      {4'd4,  1'b1, 1'b1, 9'h0FF, 1'b1, 8'hFF, 1'b1, 1'b0}, // R4 all ones
      {4'd6,  1'b1, 1'b1, 9'h120, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 deselect
      {4'd6,  1'b1, 1'b1, 9'h055, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 stream dropped
      {4'd7,  1'b1, 1'b1, 9'h1FF, 1'b0, 8'h00, 1'b1, 1'b1}, // R7 broadcast
      {4'd4,  1'b1, 1'b1, 9'h0AA, 1'b1, 8'hAA, 1'b1, 1'b0}, // R4 after broadcast
      {4'd8,  1'b0, 1'b1, 9'h13C, 1'b1, 8'h3C, 1'b0, 1'b0}, // R8 disable + matching address
      {4'd8,  1'b0, 1'b1, 9'h012, 1'b1, 8'h12, 1'b0, 1'b0}, // R8 bypass data
      {4'd2,  1'b1, 1'b1, 9'h034, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 listen after re-enable
      {4'd10, 1'b1, 1'b0, 9'h13C, 1'b0, 8'h00, 1'b0, 1'b0}  // R10 invalid address ignored
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic en, input logic v, input logic [8:0] c);
      filt_en  = en;
      rx_valid = v;
      rx_char  = c;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: state during and right after reset
      check("R9", "selected in reset", {31'd0, selected}, 32'd0);
      check("R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "addr_hit after reset", {31'd0, addr_hit}, 32'd0);
      check("R9", "selected after reset", {31'd0, selected}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         automatic logic [25:0] e = VEC[i];
         automatic string rq = $sformatf("R%0d", e[25:22]);
         put(e[21], e[20], e[19:11]);
         check(rq, $sformatf("v%0d out_valid", i), {31'd0, out_valid}, {31'd0, e[10]});
         if (e[10]) begin
            check(rq, $sformatf("v%0d out_data", i), {24'd0, out_data}, {24'd0, e[9:2]});
         end
         check(rq, $sformatf("v%0d selected", i), {31'd0, selected}, {31'd0, e[1]});
         check(rq, $sformatf("v%0d addr_hit", i), {31'd0, addr_hit}, {31'd0, e[0]});
      end

      // R3: hit pulse lasts exactly one cycle
      put(1'b1, 1'b1, 9'h13C);
      check("R3", "hit first cycle", {31'd0, addr_hit}, 32'd1);
      @(negedge clk);
      check("R3", "hit gone", {31'd0, addr_hit}, 32'd0);
      check("R3", "still selected", {31'd0, selected}, 32'd1);

      // R9: reset while selected
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "deselected by reset", {31'd0, selected}, 32'd0);
      put(1'b1, 1'b1, 9'h066);
      check("R9", "listening after reset", {31'd0, out_valid}, 32'd0);

      // R3: new node address takes effect; old one no longer matches
      node_addr = 8'h81;
      put(1'b1, 1'b1, 9'h13C);
      check("R6", "old address mismatch", {31'd0, selected}, 32'd0);
      put(1'b1, 1'b1, 9'h181);
      check("R3", "new address selects", {31'd0, selected}, 32'd1);
      check("R3", "new address hit", {31'd0, addr_hit}, 32'd1);
      put(1'b1, 1'b1, 9'h05A);
      check("R4", "payload after new address", {24'd0, out_data}, 32'h5A);
      check("R4", "valid after new address", {31'd0, out_valid}, 32'd1);

      // R1: back-to-back characters, each one cycle late
      put(1'b1, 1'b1, 9'h011);
      check("R1", "first of burst", {24'd0, out_data}, 32'h11);
      put(1'b1, 1'b1, 9'h022);
      check("R1", "second of burst", {24'd0, out_data}, 32'h22);
      @(negedge clk);
      check("R1", "strobe ends", {31'd0, out_valid}, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule